// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block is the per-core monitor behind load-exclusive / store-exclusive pairs. An exclusive load opens a reservation. The reservation holds two things: the exact address and the transaction size of that load. A later exclusive store asks the monitor whether the reservation is still intact, and the monitor answers pass or fail. The core combines that answer with the result from the shared monitor before it commits the store. Memory, caches and the shared monitor sit outside this block.

The monitor takes at most one request per cycle, from four mutually exclusive strobes: plain load, plain store, exclusive load and exclusive store. Each request carries an address and a size. The reservation is fragile on purpose:

- Any plain load or store made while a reservation is held drops it, whatever the address.
- Every exclusive store consumes the reservation, whether it passes or fails.

The current state, tag and recorded size are visible on output ports so the core pipeline can observe the reservation.

Top module: `excl_monitor`

## Requirements
- R1: Reset (rst_ni low) leaves the monitor open (excl_o=0), with tag_addr_o=0, tag_size_o=0 (none) and stx_vld_o=0.
- R2: An exclusive load moves the monitor to exclusive in the next cycle and records its address and size. It replaces any earlier reservation.
- R3: A plain load made while exclusive returns the monitor to open with tag and size cleared, for any address.
- R4: A plain store made while exclusive returns the monitor to open with tag and size cleared, for any address.
- R5: An exclusive store made while exclusive passes (stx_fail_o=0) only when its address equals the tag bit for bit and its size equals the recorded size. Otherwise it fails (stx_fail_o=1).
- R6: After any exclusive store made while exclusive, pass or fail, the monitor is open with tag and size cleared.
- R7: An exclusive store made while open fails, and the monitor stays open and cleared.
- R8: A plain load or store made while open changes nothing: the monitor stays open and cleared.
- R9: stx_vld_o is high in exactly the cycle after an exclusive-store request, and stx_fail_o carries that request's result in the same cycle (0 = pass, 1 = fail).
- R10: Size encoding on size_i and tag_size_o: 2'b00 none, 2'b01 byte, 2'b10 halfword, 2'b11 word. Each code is recorded as given.
- R11: At most one of ld_i, st_i, ldx_i, stx_i is high in any cycle. More than one is a usage error, flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_i | input | 1 | Plain load request |
| st_i | input | 1 | Plain store request |
| ldx_i | input | 1 | Exclusive load request |
| stx_i | input | 1 | Exclusive store request |
| addr_i | input | ADDR_W | Request address |
| size_i | input | 2 | Request transaction size |
| stx_vld_o | output | 1 | Exclusive-store result valid |
| stx_fail_o | output | 1 | Exclusive-store result, 1 = fail |
| excl_o | output | 1 | Monitor is in the exclusive state |
| tag_addr_o | output | ADDR_W | Reserved address |
| tag_size_o | output | 2 | Reserved transaction size |

## Verification
The bench builds the monitor with ADDR_W=4. With that width it can pair every reserved address and size with every exclusive-store address and size: 4096 reservation/store combinations. This covers every single-bit and multi-bit address mismatch, and every size mismatch, for the pass/fail decision. Using the same narrow width, it also sweeps the whole address space with plain loads and stores, both over a live reservation and over an open monitor. This shows that clearing never depends on the address.

// File: rtl/lxmon_pkg.sv
package lxmon_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } xsize_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_LD   = 3'd1,
    OP_ST   = 3'd2,
    OP_LDX  = 3'd3,
    OP_STX  = 3'd4
  } req_op_e;

endpackage

// File: rtl/lxmon_decode.sv
module lxmon_decode
  import lxmon_pkg::*;
(
  input  logic    ld_i,
  input  logic    st_i,
  input  logic    ldx_i,
  input  logic    stx_i,
  output req_op_e op_o
);

  // Strobes are one-hot by contract; fixed priority only keeps decode defined.
  always_comb begin
    if (ldx_i)      op_o = OP_LDX;
    else if (stx_i) op_o = OP_STX;
    else if (st_i)  op_o = OP_ST;
    else if (ld_i)  op_o = OP_LD;
    else            op_o = OP_IDLE;
  end

endmodule

// File: rtl/lxmon_match.sv
module lxmon_match
  import lxmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [ADDR_W-1:0] tag_addr_i,
  input  xsize_e            req_size_i,
  input  xsize_e            tag_size_i,
  output logic              hit_o
);

  logic [ADDR_W-1:0] bit_eq;

  // Exact compare, no granule masking.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_eq[i] = ~(req_addr_i[i] ^ tag_addr_i[i]);
  end

  assign hit_o = (&bit_eq) && (req_size_i == tag_size_i);

endmodule

// File: rtl/lxmon_state.sv
module lxmon_state
  import lxmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  req_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  xsize_e            size_i,
  input  logic              hit_i,
  output mon_state_e        state_o,
  output logic [ADDR_W-1:0] tag_o,
  output xsize_e            tag_size_o,
  output logic              stx_vld_o,
  output logic              stx_fail_o
);

  mon_state_e        state_q;
  logic [ADDR_W-1:0] tag_q;
  xsize_e            size_q;
  logic              vld_q;
  logic              fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_OPEN;
      tag_q   <= '0;
      size_q  <= SZ_NONE;
      vld_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      vld_q <= (op_i == OP_STX);
      case (op_i)
        OP_LDX: begin
          state_q <= MON_EXCL;
          tag_q   <= addr_i;
          size_q  <= size_i;
        end
        OP_LD, OP_ST: begin
          if (state_q == MON_EXCL) begin
            state_q <= MON_OPEN;
            tag_q   <= '0;
            size_q  <= SZ_NONE;
          end
        end
        OP_STX: begin
          fail_q <= !((state_q == MON_EXCL) && hit_i);
          if (state_q == MON_EXCL) begin
            state_q <= MON_OPEN;
            tag_q   <= '0;
            size_q  <= SZ_NONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign state_o    = state_q;
  assign tag_o      = tag_q;
  assign tag_size_o = size_q;
  assign stx_vld_o  = vld_q;
  assign stx_fail_o = fail_q;

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import lxmon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              st_i,
  input  logic              ldx_i,
  input  logic              stx_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              stx_vld_o,
  output logic              stx_fail_o,
  output logic              excl_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  output logic [1:0]        tag_size_o
);

  req_op_e           op;
  mon_state_e        state;
  logic [ADDR_W-1:0] tag;
  xsize_e            tag_size;
  xsize_e            req_size;
  logic              hit;

  assign req_size = xsize_e'(size_i);

  lxmon_decode u_decode (
    .ld_i  (ld_i),
    .st_i  (st_i),
    .ldx_i (ldx_i),
    .stx_i (stx_i),
    .op_o  (op)
  );

  lxmon_match #(.ADDR_W(ADDR_W)) u_match (
    .req_addr_i (addr_i),
    .tag_addr_i (tag),
    .req_size_i (req_size),
    .tag_size_i (tag_size),
    .hit_o      (hit)
  );

  lxmon_state #(.ADDR_W(ADDR_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .addr_i     (addr_i),
    .size_i     (req_size),
    .hit_i      (hit),
    .state_o    (state),
    .tag_o      (tag),
    .tag_size_o (tag_size),
    .stx_vld_o  (stx_vld_o),
    .stx_fail_o (stx_fail_o)
  );

  assign excl_o     = (state == MON_EXCL);
  assign tag_addr_o = tag;
  assign tag_size_o = tag_size;

endmodule

// File: rtl/lxmon_checker.sv
module lxmon_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_i,
  input logic              st_i,
  input logic              ldx_i,
  input logic              stx_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              stx_vld_o,
  input logic              stx_fail_o,
  input logic              excl_o,
  input logic [ADDR_W-1:0] tag_addr_o,
  input logic [1:0]        tag_size_o
);

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_i, st_i, ldx_i, stx_i})); // R11

  AST_OPEN_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !excl_o |-> (tag_addr_o == '0 && tag_size_o == 2'd0)); // R1

  AST_LDX_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldx_i |=> (excl_o && tag_addr_o == $past(addr_i) && tag_size_o == $past(size_i))); // R2

  AST_PLAIN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i || st_i) |=> (!excl_o && tag_addr_o == '0 && tag_size_o == 2'd0)); // R3 R4

  AST_STX_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && excl_o && addr_i == tag_addr_o && size_i == tag_size_o) |=> !stx_fail_o); // R5

  AST_STX_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && !(excl_o && addr_i == tag_addr_o && size_i == tag_size_o)) |=> stx_fail_o); // R5

  AST_STX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> (!excl_o && tag_addr_o == '0)); // R6

  AST_OPEN_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stx_i && !excl_o) |=> (stx_fail_o && !excl_o)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_i || st_i || ldx_i || stx_i) |=> ($stable(excl_o) && $stable(tag_addr_o) && $stable(tag_size_o))); // R8

  AST_VLD_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stx_i |=> stx_vld_o); // R9

  AST_VLD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stx_i |=> !stx_vld_o); // R9

endmodule

bind excl_monitor lxmon_checker #(.ADDR_W(ADDR_W)) u_lxmon_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ld_i       (ld_i),
  .st_i       (st_i),
  .ldx_i      (ldx_i),
  .stx_i      (stx_i),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .stx_vld_o  (stx_vld_o),
  .stx_fail_o (stx_fail_o),
  .excl_o     (excl_o),
  .tag_addr_o (tag_addr_o),
  .tag_size_o (tag_size_o)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;

  localparam int AW = 4;
  localparam int K_LD = 0, K_ST = 1, K_LDX = 2, K_STX = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_i = 1'b0, st_i = 1'b0, ldx_i = 1'b0, stx_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [1:0]    size_i = '0;
  logic          stx_vld_o, stx_fail_o, excl_o;
  logic [AW-1:0] tag_addr_o;
  logic [1:0]    tag_size_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  excl_monitor #(.ADDR_W(AW)) dut (
    .clk_i, .rst_ni, .ld_i, .st_i, .ldx_i, .stx_i, .addr_i, .size_i,
    .stx_vld_o, .stx_fail_o, .excl_o, .tag_addr_o, .tag_size_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One request for one cycle; returns at the negedge after the capturing edge.
  task automatic req(input int kind, input int a, input int s);
    @(negedge clk_i);
    ld_i  = (kind == K_LD);
    st_i  = (kind == K_ST);
    ldx_i = (kind == K_LDX);
    stx_i = (kind == K_STX);
    addr_i = AW'(a);
    size_i = 2'(s);
    @(negedge clk_i);
    ld_i = 0; st_i = 0; ldx_i = 0; stx_i = 0;
  endtask

  task automatic chk_open(input string r);
    chk(excl_o == 1'b0, r, excl_o, 0);
    chk(tag_addr_o == '0, r, tag_addr_o, 0);
    chk(tag_size_o == 2'd0, r, tag_size_o, 0);
  endtask

  initial begin
    // Bench keeps strobes one-hot throughout (R11).
    repeat (3) @(negedge clk_i);
    chk_open("R1 reset");
    chk(stx_vld_o == 1'b0, "R1 vld", stx_vld_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_open("R1 after release");

    // Full sweep: reservation (a,s) against exclusive store (b,t).
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 16; b++)
          for (int t = 0; t < 4; t++) begin
            req(K_LDX, a, s);
            if (b == 0 && t == 0) begin
              chk(excl_o == 1'b1, "R2 excl", excl_o, 1);
              chk(tag_addr_o == AW'(a), "R2 tag", tag_addr_o, a);
              chk(tag_size_o == 2'(s), "R10 size code", tag_size_o, s);
            end
            req(K_STX, b, t);
            chk(stx_vld_o == 1'b1, "R9 vld", stx_vld_o, 1);
            chk(stx_fail_o == !(a == b && s == t), "R5 result", stx_fail_o, !(a == b && s == t));
            chk_open("R6 cleared");
          end

    @(negedge clk_i);
    chk(stx_vld_o == 1'b0, "R9 vld single cycle", stx_vld_o, 0);

    // Replacement of an earlier reservation.
    req(K_LDX, 3, 3);
    req(K_LDX, 5, 1);
    chk(tag_addr_o == AW'(5), "R2 replace tag", tag_addr_o, 5);
    chk(tag_size_o == 2'd1, "R2 replace size", tag_size_o, 1);
    req(K_STX, 3, 3);
    chk(stx_fail_o == 1'b1, "R2 old tag fails", stx_fail_o, 1);
    req(K_LDX, 3, 3);
    req(K_LDX, 5, 1);
    req(K_STX, 5, 1);
    chk(stx_fail_o == 1'b0, "R2 new tag passes", stx_fail_o, 0);

    // Plain loads / stores over a live reservation, every address.
    for (int b = 0; b < 16; b++) begin
      req(K_LDX, 7, 2);
      req(K_LD, b, 3);
      chk_open("R3 load clears");
      req(K_STX, 7, 2);
      chk(stx_fail_o == 1'b1, "R3 reservation gone", stx_fail_o, 1);
      req(K_LDX, 7, 2);
      req(K_ST, b, 1);
      chk_open("R4 store clears");
      req(K_STX, 7, 2);
      chk(stx_fail_o == 1'b1, "R4 reservation gone", stx_fail_o, 1);
    end

    // Exclusive store and plain accesses while open.
    for (int b = 0; b < 16; b++) begin
      req(K_STX, b, b % 4);
      chk(stx_vld_o == 1'b1, "R7 vld", stx_vld_o, 1);
      chk(stx_fail_o == 1'b1, "R7 open fails", stx_fail_o, 1);
      chk_open("R7 stays open");
      req(K_LD, b, 2);
      chk_open("R8 load while open");
      chk(stx_vld_o == 1'b0, "R9 no vld on load", stx_vld_o, 0);
      req(K_ST, b, 3);
      chk_open("R8 store while open");
    end

    // Reset mid-reservation.
    req(K_LDX, 9, 3);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_open("R1 reset clears");
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule